// File: doc/BRIEF.md
# Decimal Matrix Code Memory Protector

This unit sits between a memory array and the logic that uses it, and guards each 32-bit word against multiple-cell upsets. The word is cut into eight 4-bit symbols arranged as a grid of two rows and four columns. On a write, the unit produces two groups of check bits for the memory to store next to the data. The horizontal group holds arithmetic sums of symbol pairs within each row. The vertical group holds the bitwise XOR of the symbols stacked in each column.

On a read, the stored word and its check bits come back in. The same encoder that served writes recomputes both groups. The unit then forms a horizontal syndrome by integer subtraction and a vertical syndrome by XOR. With these it repairs errors that stay within one row per column, or it reports that the damage cannot be repaired. There is a single encoder instance. The read strobe switches it from write encoding to syndrome generation, and when both strobes are high the read takes it.

Top module: `dmc_protector`

## Requirements
- R1: Symbol s = 4*row + col occupies data bits [4s+3:4s]. Horizontal check field q = 2*row + p (p = 0 or 1) occupies bits [5q+4:5q] and equals the 5-bit unsigned sum of the symbols in columns p and p+2 of that row.
- R2: Vertical check field c occupies bits [4c+3:4c] and equals the XOR of the row-0 and row-1 symbols of column c.
- R3: While wr_en is high and rd_en is low, the check outputs carry the encoding of wr_data in the same cycle. In every other cycle they are zero, because the read owns the shared encoder. A read issued together with a write is still served correctly.
- R4: rd_valid is high in exactly the cycle after each cycle in which rd_en was high, so back-to-back reads give back-to-back results.
- R5: A read whose word and check bits agree returns the word unchanged, with rd_corrected and rd_uncorr low.
- R6: Errors confined to the check bits, whether horizontal only or vertical only, return the data unchanged with both flags low.
- R7: When both syndromes are nonzero and each column with a nonzero vertical syndrome has exactly one flagged row pair, the data of each symbol in a flagged pair is XORed with its column's vertical syndrome, and rd_corrected is raised.
- R8: When both syndromes are nonzero but the pattern is inconsistent, rd_uncorr is raised and the raw read word is returned. Inconsistent means two rows flagged for one column, or a flagged pair whose columns show no vertical syndrome.
- R9: After a synchronous active-high reset, rd_valid, rd_data and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Word to be written |
| wr_chk_h | output | 20 | Horizontal check bits for the written word |
| wr_chk_v | output | 16 | Vertical check bits for the written word |
| rd_en | input | 1 | Read strobe |
| rd_word | input | 32 | Stored word returned by memory |
| rd_chk_h | input | 20 | Stored horizontal check bits |
| rd_chk_v | input | 16 | Stored vertical check bits |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Corrected (or raw) read data |
| rd_corrected | output | 1 | A correction was applied |
| rd_uncorr | output | 1 | Uncorrectable error detected |

## Verification
The write check bits are combinational, so they are due in the same cycle as the write strobe. The bench drives them on a falling edge and samples one time unit later. Read data and flags pass through one register and are due at the rising edge that follows the strobe. The bench therefore drives a read on a falling edge and samples at the next falling edge, when exactly one register stage has updated. The back-to-back read test checks both results at those points, and checks that rd_valid drops one cycle after the strobe ends.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic {
    ENC_WRITE = 1'b0,
    ENC_READ  = 1'b1
  } enc_mode_e;
endpackage

// File: rtl/dmc_encoder.sv
module dmc_encoder #(
  parameter int SYM_W = 4,
  parameter int ROWS  = 2,
  parameter int COLS  = 4
) (
  input  logic [SYM_W*ROWS*COLS-1:0]        data,
  output logic [ROWS*(COLS/2)*(SYM_W+1)-1:0] hsum,
  output logic [COLS*SYM_W-1:0]             vpar
);
  localparam int HALF   = COLS / 2;
  localparam int PAIR_W = SYM_W + 1;

  // pair sums: column p joined with column p+HALF in each row
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar p = 0; p < HALF; p++) begin : g_pair
      assign hsum[(r*HALF+p)*PAIR_W +: PAIR_W] =
        {1'b0, data[(r*COLS+p)*SYM_W +: SYM_W]} +
        {1'b0, data[(r*COLS+p+HALF)*SYM_W +: SYM_W]};
    end
  end

  // column parity across all rows
  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [SYM_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int r = 0; r < ROWS; r++) begin
        acc = acc ^ data[(r*COLS+c)*SYM_W +: SYM_W];
      end
    end
    assign vpar[c*SYM_W +: SYM_W] = acc;
  end
endmodule

// File: rtl/dmc_syndrome.sv
module dmc_syndrome #(
  parameter int SYM_W = 4,
  parameter int ROWS  = 2,
  parameter int COLS  = 4
) (
  input  logic [ROWS*(COLS/2)*(SYM_W+1)-1:0] hsum_new,
  input  logic [ROWS*(COLS/2)*(SYM_W+1)-1:0] hsum_old,
  input  logic [COLS*SYM_W-1:0]              vpar_new,
  input  logic [COLS*SYM_W-1:0]              vpar_old,
  output logic [ROWS*(COLS/2)-1:0]           pair_flag,
  output logic [COLS*SYM_W-1:0]              col_syn
);
  localparam int NPAIR  = ROWS * (COLS / 2);
  localparam int PAIR_W = SYM_W + 1;

  // integer difference per pair; any nonzero difference flags it
  for (genvar q = 0; q < NPAIR; q++) begin : g_diff
    logic [PAIR_W:0] diff;
    assign diff = {1'b0, hsum_new[q*PAIR_W +: PAIR_W]} -
                  {1'b0, hsum_old[q*PAIR_W +: PAIR_W]};
    assign pair_flag[q] = |diff;
  end

  assign col_syn = vpar_new ^ vpar_old;
endmodule

// File: rtl/dmc_corrector.sv
module dmc_corrector #(
  parameter int SYM_W = 4,
  parameter int ROWS  = 2,
  parameter int COLS  = 4
) (
  input  logic [SYM_W*ROWS*COLS-1:0] raw,
  input  logic [ROWS*(COLS/2)-1:0]   pair_flag,
  input  logic [COLS*SYM_W-1:0]      col_syn,
  output logic [SYM_W*ROWS*COLS-1:0] fixed,
  output logic                       corrected,
  output logic                       uncorrectable
);
  localparam int HALF  = COLS / 2;
  localparam int NPAIR = ROWS * HALF;
  localparam int DW    = SYM_W * ROWS * COLS;
  localparam int CW    = $clog2(ROWS + 1);

  logic [COLS-1:0]  col_nz;
  logic [COLS-1:0]  col_bad;
  logic [NPAIR-1:0] pair_bad;
  logic [DW-1:0]    flip;
  logic             both_nz;
  logic             inconsistent;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [CW-1:0] hits;
    assign col_nz[c] = |col_syn[c*SYM_W +: SYM_W];
    always_comb begin
      hits = '0;
      for (int r = 0; r < ROWS; r++) begin
        hits = hits + CW'(pair_flag[r*HALF + (c % HALF)]);
      end
    end
    // a column with syndrome must point at exactly one row
    assign col_bad[c] = col_nz[c] && (hits != CW'(1));
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar p = 0; p < HALF; p++) begin : g_pair
      assign pair_bad[r*HALF+p] = pair_flag[r*HALF+p] && !col_nz[p] && !col_nz[p+HALF];
    end
    for (genvar c = 0; c < COLS; c++) begin : g_sym
      assign flip[(r*COLS+c)*SYM_W +: SYM_W] =
        pair_flag[r*HALF + (c % HALF)] ? col_syn[c*SYM_W +: SYM_W] : '0;
    end
  end

  assign both_nz       = (|pair_flag) && (|col_nz);
  assign inconsistent  = (|col_bad) || (|pair_bad);
  assign corrected     = both_nz && !inconsistent;
  assign uncorrectable = both_nz && inconsistent;
  assign fixed         = corrected ? (raw ^ flip) : raw;
endmodule

// File: rtl/dmc_protector.sv
module dmc_protector #(
  parameter int SYM_W = 4,
  parameter int ROWS  = 2,
  parameter int COLS  = 4,
  localparam int DW   = SYM_W * ROWS * COLS,
  localparam int HW   = ROWS * (COLS / 2) * (SYM_W + 1),
  localparam int VW   = COLS * SYM_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [HW-1:0] wr_chk_h,
  output logic [VW-1:0] wr_chk_v,
  input  logic          rd_en,
  input  logic [DW-1:0] rd_word,
  input  logic [HW-1:0] rd_chk_h,
  input  logic [VW-1:0] rd_chk_v,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          rd_corrected,
  output logic          rd_uncorr
);
  import dmc_pkg::*;

  localparam int NPAIR = ROWS * (COLS / 2);

  enc_mode_e        mode;
  logic [DW-1:0]    enc_in;
  logic [HW-1:0]    enc_h;
  logic [VW-1:0]    enc_v;
  logic [NPAIR-1:0] pair_flag;
  logic [VW-1:0]    col_syn;
  logic [DW-1:0]    fixed;
  logic             fix_ok;
  logic             fix_bad;

  // the read strobe claims the single encoder
  assign mode   = rd_en ? ENC_READ : ENC_WRITE;
  assign enc_in = (mode == ENC_READ) ? rd_word : wr_data;

  dmc_encoder #(.SYM_W(SYM_W), .ROWS(ROWS), .COLS(COLS)) u_enc (
    .data (enc_in),
    .hsum (enc_h),
    .vpar (enc_v)
  );

  assign wr_chk_h = (mode == ENC_WRITE && wr_en) ? enc_h : '0;
  assign wr_chk_v = (mode == ENC_WRITE && wr_en) ? enc_v : '0;

  dmc_syndrome #(.SYM_W(SYM_W), .ROWS(ROWS), .COLS(COLS)) u_syn (
    .hsum_new  (enc_h),
    .hsum_old  (rd_chk_h),
    .vpar_new  (enc_v),
    .vpar_old  (rd_chk_v),
    .pair_flag (pair_flag),
    .col_syn   (col_syn)
  );

  dmc_corrector #(.SYM_W(SYM_W), .ROWS(ROWS), .COLS(COLS)) u_cor (
    .raw           (rd_word),
    .pair_flag     (pair_flag),
    .col_syn       (col_syn),
    .fixed         (fixed),
    .corrected     (fix_ok),
    .uncorrectable (fix_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid     <= 1'b0;
      rd_data      <= '0;
      rd_corrected <= 1'b0;
      rd_uncorr    <= 1'b0;
    end else begin
      rd_valid     <= rd_en;
      rd_corrected <= rd_en && fix_ok;
      rd_uncorr    <= rd_en && fix_bad;
      if (rd_en) begin
        rd_data <= fixed;
      end
    end
  end

  // R4
  valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  // R4
  no_stray_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));
  // R8
  uncorr_raw_chk: assert property (@(posedge clk) disable iff (rst)
    rd_uncorr |-> (rd_data == $past(rd_word)) && !rd_corrected);
  // R7
  fix_changes_chk: assert property (@(posedge clk) disable iff (rst)
    rd_corrected |-> rd_data != $past(rd_word));
  // R3
  idle_chk_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && !rd_en) |-> (wr_chk_h == '0) && (wr_chk_v == '0));
  // R6
  flags_need_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> !rd_corrected && !rd_uncorr);
endmodule

// File: tb/test_dmc_protector.sv
module test_dmc_protector;
  localparam int CLK_PER = 10;
  localparam int NVEC    = 11;

  typedef struct packed {
    logic [31:0] data;
    logic [31:0] dmask;
    logic [19:0] hmask;
    logic [15:0] vmask;
    logic        exp_fix;
    logic        exp_bad;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{32'h12345678, 32'h00000000, 20'h0,     16'h0,    1'b0, 1'b0},
    '{32'hDEADBEEF, 32'h00000001, 20'h0,     16'h0,    1'b1, 1'b0},
    '{32'hA5A5A5A5, 32'h000F0000, 20'h0,     16'h0,    1'b1, 1'b0},
    '{32'h0F1E2D3C, 32'h00000033, 20'h0,     16'h0,    1'b1, 1'b0},
    '{32'h00000000, 32'h00001111, 20'h0,     16'h0,    1'b1, 1'b0},
    '{32'hFFFFFFFF, 32'h00001111, 20'h0,     16'h0,    1'b1, 1'b0},
    '{32'h00000000, 32'h80000000, 20'h0,     16'h0,    1'b1, 1'b0},
    '{32'hCAFEF00D, 32'h00000000, 20'h00001, 16'h0,    1'b0, 1'b0},
    '{32'hCAFEF00D, 32'h00000000, 20'h0,     16'h0100, 1'b0, 1'b0},
    '{32'h13572468, 32'h00020001, 20'h0,     16'h0,    1'b0, 1'b1},
    '{32'h89ABCDEF, 32'h00000001, 20'h08000, 16'h0,    1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [19:0] wr_chk_h;
  logic [15:0] wr_chk_v;
  logic        rd_en = 1'b0;
  logic [31:0] rd_word = '0;
  logic [19:0] rd_chk_h = '0;
  logic [15:0] rd_chk_v = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        rd_corrected;
  logic        rd_uncorr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  dmc_protector i_dmc_protector (
    .clk, .rst, .wr_en, .wr_data, .wr_chk_h, .wr_chk_v,
    .rd_en, .rd_word, .rd_chk_h, .rd_chk_v,
    .rd_valid, .rd_data, .rd_corrected, .rd_uncorr
  );

  function automatic logic [35:0] ref_enc(input logic [31:0] d);
    logic [19:0] h;
    logic [15:0] v;
    for (int r = 0; r < 2; r++)
      for (int p = 0; p < 2; p++)
        h[(r*2+p)*5 +: 5] = {1'b0, d[(r*4+p)*4 +: 4]} + {1'b0, d[(r*4+p+2)*4 +: 4]};
    for (int c = 0; c < 4; c++)
      v[c*4 +: 4] = d[c*4 +: 4] ^ d[(4+c)*4 +: 4];
    return {h, v};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic do_read(input logic [31:0] w, input logic [19:0] h, input logic [15:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_word = w; rd_chk_h = h; rd_chk_v = v;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    #(CLK_PER * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [35:0] enc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    check("R9", {rd_valid, rd_corrected, rd_uncorr, rd_data}, '0);
    // R3 idle check outputs
    #1 check("R3", {wr_chk_h, wr_chk_v}, '0);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_data = VECS[i].data;
      #1;
      enc = ref_enc(VECS[i].data);
      check("R1", wr_chk_h, enc[35:16]);
      check("R2", wr_chk_v, enc[15:0]);
      @(negedge clk);
      wr_en = 1'b0;
      do_read(VECS[i].data ^ VECS[i].dmask, enc[35:16] ^ VECS[i].hmask,
              enc[15:0] ^ VECS[i].vmask);
      check("R4", rd_valid, 1);
      if (VECS[i].exp_bad) begin
        check("R8", rd_data, VECS[i].data ^ VECS[i].dmask);
        check("R8", {rd_corrected, rd_uncorr}, 2'b01);
      end else if (VECS[i].exp_fix) begin
        check("R7", rd_data, VECS[i].data);
        check("R7", {rd_corrected, rd_uncorr}, 2'b10);
      end else if (VECS[i].hmask != 0 || VECS[i].vmask != 0) begin
        check("R6", rd_data, VECS[i].data);
        check("R6", {rd_corrected, rd_uncorr}, 2'b00);
      end else begin
        check("R5", rd_data, VECS[i].data);
        check("R5", {rd_corrected, rd_uncorr}, 2'b00);
      end
      @(negedge clk);
      check("R4", rd_valid, 0);
    end

    // R3 read and write together: read wins the encoder
    enc = ref_enc(32'h0BADC0DE);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 32'h11111111;
    rd_en = 1'b1; rd_word = 32'h0BADC0DE; rd_chk_h = enc[35:16]; rd_chk_v = enc[15:0];
    #1 check("R3", {wr_chk_h, wr_chk_v}, '0);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R3", {rd_valid, rd_corrected, rd_uncorr, rd_data}, {3'b100, 32'h0BADC0DE});

    // R4 back-to-back reads
    @(negedge clk);
    enc = ref_enc(32'h01234567);
    rd_en = 1'b1; rd_word = 32'h01234567; rd_chk_h = enc[35:16]; rd_chk_v = enc[15:0];
    @(negedge clk);
    check("R4", {rd_valid, rd_data}, {1'b1, 32'h01234567});
    enc = ref_enc(32'h76543210);
    rd_word = 32'h76543210 ^ 32'h00400000; rd_chk_h = enc[35:16]; rd_chk_v = enc[15:0];
    @(negedge clk);
    rd_en = 1'b0;
    check("R4", {rd_valid, rd_corrected, rd_data}, {2'b11, 32'h76543210});
    @(negedge clk);
    check("R4", {rd_valid, rd_corrected, rd_uncorr}, 3'b000);

    // R9 reset clears a loaded output
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9", {rd_valid, rd_corrected, rd_uncorr, rd_data}, '0);

    done = 1'b1;
    finish_run();
  end
endmodule